// File: doc/BRIEF.md
# Breakpoint Trigger Pair Combiner

This block turns the raw match results of a bank of hardware breakpoint triggers into trap decisions. The triggers sit in fixed, adjacent pairs, and a pair can be linked so that its two members act as one compound condition. Address and data comparison happens elsewhere. For the instruction currently presented, the block takes one precomputed hit bit per trigger. It returns which triggers fire, whether a trap is due on this instruction, and whether a trap is owed to the next instruction.

Each trigger's settings live in a register bank written through a valid-qualified port that selects one trigger by index. The settings are: enable, link request, timing, a 2-bit match type, a select bit, an action bit and a compare value. A read port returns one trigger's settings to the comparators outside the block.

The member kinds repeat per pair as (fetch,fetch), (store,store), (load,load), (fetch,store), (fetch,load). Linking two store triggers is not permitted, so the link request of the store/store pair has no effect. A trap owed to the next instruction is held in a pending flag. That flag is paid out on the next valid instruction and dropped by a flush.

Top module: `tcf_chain_eval`

## Requirements
- R1: After reset every stored setting reads back as zero, the pending flag is clear, and no trigger fires even with all hit bits set.
- R2: A write with `cfg_we` high stores all fields into trigger `cfg_idx`; they are visible on the read port from the next cycle. An index of 10 or more changes nothing and reads back as zero.
- R3: While `insn_valid` is low, `fire_o` is all zero and `trap_now_o` is low.
- R4: In an unlinked pair, trigger k fires when `insn_valid`, its enable and `hit[k]` are all high, whatever its partner does.
- R5: Pair i is linked when the link field of its lower trigger (index 2i) is set. Both members then fire together, and only when both are enabled and both report a hit.
- R6: In a linked pair whose two timing fields differ, neither member fires.
- R7: Pair 1 (triggers 2 and 3, both store kind) ignores its link field, and its members fire independently.
- R8: `trap_now_o` is high in the same cycle that any trigger with timing 0 fires.
- R9: A firing trigger with timing 1 sets the pending flag (`pend_o`) at the next clock edge. While pending, the next cycle with `insn_valid` high raises `trap_next_o`, and that edge clears the flag unless a new timing-1 fire sets it again.
- R10: `flush` clears the pending flag at the next edge, stops a same-cycle timing-1 fire from setting it, and masks `trap_next_o`.
- R11: A disabled trigger never fires and does not satisfy its partner's linked hit requirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| cfg_we | input | 1 | Settings write strobe |
| cfg_idx | input | 4 | Trigger index for the write |
| cfg_en | input | 1 | Enable to store |
| cfg_mtype | input | 2 | Match type to store |
| cfg_sel | input | 1 | Select bit to store |
| cfg_tim | input | 1 | Timing to store (0 = this instruction, 1 = next) |
| cfg_act | input | 1 | Action bit to store |
| cfg_chain | input | 1 | Link request to store |
| cfg_value | input | 64 | Compare value to store |
| rd_idx | input | 4 | Trigger index for the read port |
| rd_en | output | 1 | Stored enable |
| rd_mtype | output | 2 | Stored match type |
| rd_sel | output | 1 | Stored select bit |
| rd_tim | output | 1 | Stored timing |
| rd_act | output | 1 | Stored action bit |
| rd_chain | output | 1 | Stored link request |
| rd_value | output | 64 | Stored compare value |
| insn_valid | input | 1 | A valid instruction is presented this cycle |
| hit | input | 10 | Per-trigger precomputed match |
| flush | input | 1 | Pipeline flush, drops pending trap |
| fire_o | output | 10 | Per-trigger fire |
| trap_now_o | output | 1 | Trap on the current instruction |
| trap_next_o | output | 1 | Owed trap paid out on this instruction |
| pend_o | output | 1 | Trap owed to the next instruction |

## Verification
The assertions assume that `hit` carries meaning only while `insn_valid` is high. They also assume that settings do not change in the same cycle as an evaluation they are meant to affect. The stimulus performs every settings write with `insn_valid` low and leaves one idle edge before the evaluation that depends on it. Flush is raised only in directed cycles, so the pending checks see each clear/set priority case in isolation.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_STORE = 2'd1,
    KIND_LOAD  = 2'd2
  } trig_kind_e;

  typedef struct packed {
    logic       en;
    logic [1:0] mtype;
    logic       sel;
    logic       tim;
    logic       act;
    logic       chain;
  } trig_ctl_t;

  localparam int KIND_PERIOD = 5;

  // Kind of a pair member; the five-pair pattern repeats for larger banks.
  function automatic trig_kind_e member_kind(input int pair, input int member);
    trig_kind_e k;
    case (pair % KIND_PERIOD)
      0:       k = KIND_FETCH;
      1:       k = KIND_STORE;
      2:       k = KIND_LOAD;
      3:       k = (member == 0) ? KIND_FETCH : KIND_STORE;
      default: k = (member == 0) ? KIND_FETCH : KIND_LOAD;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/tcf_rst_sync.sv
module tcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tcf_cfg_bank.sv
module tcf_cfg_bank
  import tcf_pkg::*;
#(
  parameter int NUM_TRIG = 10,
  parameter int IDX_W    = 4,
  parameter int CMP_W    = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  trig_ctl_t                wr_ctl,
  input  logic [CMP_W-1:0]         wr_value,
  input  logic [IDX_W-1:0]         rd_idx,
  output trig_ctl_t                rd_ctl,
  output logic [CMP_W-1:0]         rd_value,
  output trig_ctl_t [NUM_TRIG-1:0] ctl_o
);
  trig_ctl_t [NUM_TRIG-1:0]        ctl_q;
  trig_ctl_t [NUM_TRIG-1:0]        ctl_d;
  logic [NUM_TRIG-1:0][CMP_W-1:0]  val_q;
  logic [NUM_TRIG-1:0][CMP_W-1:0]  val_d;
  logic [NUM_TRIG-1:0]             slot_we;

  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_slot
    always_comb begin
      slot_we[k] = wr_en && (32'(wr_idx) == k);
      ctl_d[k]   = wr_ctl;
      val_d[k]   = wr_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[k] <= '0;
        val_q[k] <= '0;
      end else if (slot_we[k]) begin
        ctl_q[k] <= ctl_d[k];
        val_q[k] <= val_d[k];
      end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_we[k] |=> $stable(ctl_q[k]) && $stable(val_q[k])); // R2
  end

  always_comb begin
    rd_ctl   = '0;
    rd_value = '0;
    if (32'(rd_idx) < NUM_TRIG) begin
      rd_ctl   = ctl_q[rd_idx];
      rd_value = val_q[rd_idx];
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/tcf_pair.sv
module tcf_pair #(
  parameter bit NO_CHAIN = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       insn_valid,
  input  logic [1:0] en,
  input  logic [1:0] tim,
  input  logic [1:0] hit,
  input  logic       chain_req,
  output logic [1:0] fire
);
  localparam logic LINK_ALLOWED = !NO_CHAIN;

  logic [1:0] armed;
  logic       linked;
  logic       both_ok;

  always_comb begin
    armed   = en & hit & {2{insn_valid}};
    linked  = chain_req & LINK_ALLOWED;
    both_ok = (&armed) && (tim[0] == tim[1]);
    if (linked) fire = {2{both_ok}};
    else        fire = armed;
  end

  AST_PAIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> fire == 2'b00); // R3
  AST_PAIR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !linked && en[0] && hit[0] && insn_valid |-> fire[0]); // R4
  AST_PAIR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    linked |-> fire[0] == fire[1]); // R5
  AST_PAIR_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    linked && (tim[0] != tim[1]) |-> fire == 2'b00); // R6
  AST_PAIR_DIS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !en[0] |-> !fire[0]); // R11
  AST_PAIR_DIS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    !en[1] |-> !fire[1]); // R11
endmodule

// File: rtl/tcf_pending.sv
module tcf_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic insn_valid,
  input  logic flush,
  input  logic fire_next,
  output logic pend_q,
  output logic trap_next
);
  logic pend_d;
  logic pend_upd;

  always_comb begin
    pend_upd = flush | fire_next | insn_valid;
    if (flush)          pend_d = 1'b0;
    else if (fire_next) pend_d = 1'b1;
    else                pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (pend_upd) pend_q <= pend_d;
  end

  assign trap_next = pend_q & insn_valid & ~flush;

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fire_next && !flush |=> pend_q); // R9
  AST_PEND_PAID: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && insn_valid && !fire_next |=> !pend_q); // R9
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid && !flush && !fire_next |=> $stable(pend_q)); // R9
  AST_PEND_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pend_q); // R10
endmodule

// File: rtl/tcf_chain_eval.sv
module tcf_chain_eval
  import tcf_pkg::*;
#(
  parameter int NUM_PAIRS = 5,
  parameter int CMP_W     = 64,
  parameter int NUM_TRIG  = 2 * NUM_PAIRS,
  parameter int IDX_W     = $clog2(2 * NUM_PAIRS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_en,
  input  logic [1:0]          cfg_mtype,
  input  logic                cfg_sel,
  input  logic                cfg_tim,
  input  logic                cfg_act,
  input  logic                cfg_chain,
  input  logic [CMP_W-1:0]    cfg_value,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic                rd_en,
  output logic [1:0]          rd_mtype,
  output logic                rd_sel,
  output logic                rd_tim,
  output logic                rd_act,
  output logic                rd_chain,
  output logic [CMP_W-1:0]    rd_value,
  input  logic                insn_valid,
  input  logic [NUM_TRIG-1:0] hit,
  input  logic                flush,
  output logic [NUM_TRIG-1:0] fire_o,
  output logic                trap_now_o,
  output logic                trap_next_o,
  output logic                pend_o
);
  logic                      rst_sync_n;
  trig_ctl_t                 wr_ctl;
  trig_ctl_t                 rd_ctl;
  trig_ctl_t [NUM_TRIG-1:0]  ctl;
  logic [NUM_TRIG-1:0]       en_vec;
  logic [NUM_TRIG-1:0]       tim_vec;
  logic [NUM_TRIG-1:0]       fire;
  logic                      fire_now;
  logic                      fire_next;

  tcf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wr_ctl.en    = cfg_en;
    wr_ctl.mtype = cfg_mtype;
    wr_ctl.sel   = cfg_sel;
    wr_ctl.tim   = cfg_tim;
    wr_ctl.act   = cfg_act;
    wr_ctl.chain = cfg_chain;
  end

  tcf_cfg_bank #(
    .NUM_TRIG (NUM_TRIG),
    .IDX_W    (IDX_W),
    .CMP_W    (CMP_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_ctl   (wr_ctl),
    .wr_value (cfg_value),
    .rd_idx   (rd_idx),
    .rd_ctl   (rd_ctl),
    .rd_value (rd_value),
    .ctl_o    (ctl)
  );

  always_comb begin
    rd_en    = rd_ctl.en;
    rd_mtype = rd_ctl.mtype;
    rd_sel   = rd_ctl.sel;
    rd_tim   = rd_ctl.tim;
    rd_act   = rd_ctl.act;
    rd_chain = rd_ctl.chain;
  end

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_unpack
    assign en_vec[t]  = ctl[t].en;
    assign tim_vec[t] = ctl[t].tim;
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam bit STORE_PAIR = (member_kind(p, 0) == KIND_STORE) &&
                                (member_kind(p, 1) == KIND_STORE);
    tcf_pair #(.NO_CHAIN(STORE_PAIR)) u_pair (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .insn_valid (insn_valid),
      .en         (en_vec[2*p+1 -: 2]),
      .tim        (tim_vec[2*p+1 -: 2]),
      .hit        (hit[2*p+1 -: 2]),
      .chain_req  (ctl[2*p].chain),
      .fire       (fire[2*p+1 -: 2])
    );
  end

  always_comb begin
    fire_now  = |(fire & ~tim_vec);
    fire_next = |(fire & tim_vec);
  end

  tcf_pending u_pend (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .insn_valid (insn_valid),
    .flush      (flush),
    .fire_next  (fire_next),
    .pend_q     (pend_o),
    .trap_next  (trap_next_o)
  );

  assign fire_o     = fire;
  assign trap_now_o = fire_now;

  AST_TOP_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !insn_valid |-> !trap_now_o && fire_o == '0); // R3
  AST_TOP_NOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_now_o |-> fire_o != '0); // R8
  AST_TOP_FLUSH_MASK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |-> !trap_next_o); // R10
endmodule

// File: tb/tcf_chain_eval_test.sv
module tcf_chain_eval_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 10;

  logic            clk;
  logic            rst_n;
  logic            cfg_we;
  logic [3:0]      cfg_idx;
  logic            cfg_en;
  logic [1:0]      cfg_mtype;
  logic            cfg_sel;
  logic            cfg_tim;
  logic            cfg_act;
  logic            cfg_chain;
  logic [63:0]     cfg_value;
  logic [3:0]      rd_idx;
  logic            rd_en;
  logic [1:0]      rd_mtype;
  logic            rd_sel;
  logic            rd_tim;
  logic            rd_act;
  logic            rd_chain;
  logic [63:0]     rd_value;
  logic            insn_valid;
  logic [NT-1:0]   hit;
  logic            flush;
  logic [NT-1:0]   fire_o;
  logic            trap_now_o;
  logic            trap_next_o;
  logic            pend_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  tcf_chain_eval uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_mtype(cfg_mtype),
    .cfg_sel(cfg_sel), .cfg_tim(cfg_tim), .cfg_act(cfg_act), .cfg_chain(cfg_chain),
    .cfg_value(cfg_value), .rd_idx(rd_idx), .rd_en(rd_en), .rd_mtype(rd_mtype),
    .rd_sel(rd_sel), .rd_tim(rd_tim), .rd_act(rd_act), .rd_chain(rd_chain),
    .rd_value(rd_value), .insn_valid(insn_valid), .hit(hit), .flush(flush),
    .fire_o(fire_o), .trap_now_o(trap_now_o), .trap_next_o(trap_next_o), .pend_o(pend_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wcfg(input int idx, input logic en, input logic tim, input logic chain,
                      input logic [1:0] mt, input logic sel, input logic act,
                      input logic [63:0] val);
    @(negedge clk);
    insn_valid = 0; hit = '0; flush = 0;
    cfg_we = 1; cfg_idx = 4'(idx); cfg_en = en; cfg_tim = tim; cfg_chain = chain;
    cfg_mtype = mt; cfg_sel = sel; cfg_act = act; cfg_value = val;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic drive(input logic v, input logic [NT-1:0] h, input logic f);
    @(negedge clk);
    insn_valid = v; hit = h; flush = f;
    #1;
  endtask

  task automatic t_reset;
    rd_idx = 4'd0;
    drive(1, '1, 0);
    chk("R1", "fire after reset", 64'(fire_o), 0);
    chk("R1", "pend after reset", 64'(pend_o), 0);
    chk("R1", "rd value idx0", rd_value, 0);
    chk("R1", "rd fields idx0",
        64'({rd_en, rd_mtype, rd_sel, rd_tim, rd_act, rd_chain}), 0);
    drive(0, '0, 0);
  endtask

  task automatic t_cfg;
    wcfg(5, 1, 1, 0, 2'd2, 1, 1, 64'hDEAD_BEEF_0123_4567);
    rd_idx = 4'd5; #1;
    chk("R2", "rd value idx5", rd_value, 64'hDEAD_BEEF_0123_4567);
    chk("R2", "rd fields idx5",
        64'({rd_en, rd_mtype, rd_sel, rd_tim, rd_act, rd_chain}), 64'b1_10_1_1_1_0);
    wcfg(12, 1, 0, 0, 2'd1, 1, 1, 64'h1111);
    rd_idx = 4'd12; #1;
    chk("R2", "rd out-of-range idx", rd_value, 0);
    rd_idx = 4'd5; #1;
    chk("R2", "idx5 kept after bad write", rd_value, 64'hDEAD_BEEF_0123_4567);
    wcfg(5, 0, 0, 0, 2'd0, 0, 0, 64'h0);
  endtask

  task automatic t_unchained;
    wcfg(0, 1, 0, 0, 2'd0, 0, 0, 64'h0);
    wcfg(1, 1, 0, 0, 2'd0, 0, 0, 64'h0);
    drive(1, 10'b01, 0);
    chk("R4", "lone low member", 64'(fire_o), 64'b01);
    chk("R8", "trap now timing0", 64'(trap_now_o), 1);
    drive(1, 10'b10, 0);
    chk("R4", "lone high member", 64'(fire_o), 64'b10);
    drive(0, 10'b11, 0);
    chk("R3", "no fire without valid", 64'(fire_o), 0);
    chk("R3", "no trap without valid", 64'(trap_now_o), 0);
  endtask

  task automatic t_chain;
    wcfg(0, 1, 0, 1, 2'd0, 0, 0, 64'h0);
    drive(1, 10'b01, 0);
    chk("R5", "linked one hit", 64'(fire_o), 0);
    drive(1, 10'b11, 0);
    chk("R5", "linked both hit", 64'(fire_o), 64'b11);
    wcfg(1, 0, 0, 0, 2'd0, 0, 0, 64'h0);
    drive(1, 10'b11, 0);
    chk("R11", "disabled partner blocks", 64'(fire_o), 0);
    wcfg(1, 1, 1, 0, 2'd0, 0, 0, 64'h0);
    drive(1, 10'b11, 0);
    chk("R6", "timing mismatch", 64'(fire_o), 0);
    drive(0, '0, 0);
    chk("R6", "mismatch sets no pending", 64'(pend_o), 0);
    wcfg(0, 0, 0, 0, 2'd0, 0, 0, 64'h0);
    wcfg(1, 0, 0, 0, 2'd0, 0, 0, 64'h0);
  endtask

  task automatic t_store;
    wcfg(2, 1, 0, 1, 2'd0, 0, 0, 64'h0);
    wcfg(3, 1, 0, 0, 2'd0, 0, 0, 64'h0);
    drive(1, 10'b0100, 0);
    chk("R7", "store pair low alone", 64'(fire_o), 64'b0100);
    drive(1, 10'b1000, 0);
    chk("R7", "store pair high alone", 64'(fire_o), 64'b1000);
    wcfg(2, 0, 0, 0, 2'd0, 0, 0, 64'h0);
    wcfg(3, 0, 0, 0, 2'd0, 0, 0, 64'h0);
  endtask

  task automatic t_next;
    wcfg(4, 1, 0, 0, 2'd0, 0, 0, 64'h0);
    wcfg(5, 1, 1, 0, 2'd0, 0, 0, 64'h0);
    drive(1, 10'h010, 0);
    chk("R8", "now trap", 64'({trap_now_o, trap_next_o}), 64'b10);
    drive(1, 10'h020, 0);
    chk("R9", "timing1 fire", 64'(fire_o), 64'h20);
    chk("R9", "timing1 no now trap", 64'(trap_now_o), 0);
    chk("R9", "pend not yet", 64'(pend_o), 0);
    drive(0, '0, 0);
    chk("R9", "pend set", 64'(pend_o), 1);
    chk("R9", "no payout without valid", 64'(trap_next_o), 0);
    drive(0, '0, 0);
    chk("R9", "pend held idle", 64'(pend_o), 1);
    drive(1, '0, 0);
    chk("R9", "payout on next insn", 64'(trap_next_o), 1);
    drive(0, '0, 0);
    chk("R9", "pend cleared after payout", 64'(pend_o), 0);
  endtask

  task automatic t_flush;
    drive(1, 10'h020, 0);
    drive(1, '0, 1);
    chk("R10", "flush masks payout", 64'(trap_next_o), 0);
    drive(0, '0, 0);
    chk("R10", "flush cleared pend", 64'(pend_o), 0);
    drive(1, 10'h020, 1);
    chk("R10", "fire with flush", 64'(fire_o), 64'h20);
    drive(0, '0, 0);
    chk("R10", "flush blocks set", 64'(pend_o), 0);
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_idx = '0; cfg_en = 0; cfg_mtype = '0; cfg_sel = 0;
    cfg_tim = 0; cfg_act = 0; cfg_chain = 0; cfg_value = '0; rd_idx = '0;
    insn_valid = 0; hit = '0; flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg();
    t_unchained();
    t_chain();
    t_store();
    t_next();
    t_flush();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule